// File: doc/BRIEF.md
# Multicycle Eight-Register Processor

This block is a small processor core that runs one instruction at a time as a chain of single-clock micro-steps through a memory address register and a memory data register. It has eight 32-bit general registers. Register 7 doubles as the stack pointer for subroutine linkage. Each instruction word names either a primary operation with a register field and a 10-bit address, or a register-to-register operation selected by a secondary code. Every instruction class takes a fixed, known number of clocks, so software timing can be predicted exactly.

The core drives a single-port synchronous word memory. The address is presented on the same edge at which the address register loads, so the read word comes back one clock later. Writes take effect at the clock edge that ends the write step. A one-clock completion pulse marks the last clock of each instruction, and a free-running clock counter lets the surrounding system measure cycles per instruction.

Top module: `mc_cpu`

## Requirements
- R1: On synchronous active-high reset, the program counter, all eight registers and both compare flags (zero, sign) become 0. The first clock after reset is the start of a fetch from address 0.
- R2: Word encoding: the primary opcode is in bits [31:29], the register or condition field in [28:26] and the address in [9:0]. When the opcode is 7, the secondary code is in [25:23], the first register in [22:20] and the second register in [19:17].
- R3: Opcode 0 copies memory at the address field into the named register. Opcode 1 writes the named register to memory at the address field.
- R4: Opcode 2 loads the program counter from the address field when its condition holds. Conditions: 0 always, 1 zero, 2 not zero, 3 sign, 4 sign or zero, 5 not sign, 6 neither sign nor zero. Secondary code 4 sets zero when the two registers are equal and sign to bit 31 of first minus second. No other instruction changes the flags.
- R5: Secondary codes 0 (copy first register to second), 3 (first plus second into first) and 5 (increment first) use 32-bit wrap-around arithmetic.
- R6: Secondary code 1 loads the second register from memory addressed by the low 10 bits of the first register. Secondary code 2 stores the first register to memory addressed by the low 10 bits of the second.
- R7: A call (opcode 3) increments register 7, writes the return address to memory at the new register 7 value, then jumps. A return (secondary code 6) reloads the program counter from memory at register 7, then decrements register 7. Calls nest.
- R8: Total clocks per instruction, counting a 3-clock fetch: load 6, store 6, jump 5 whether taken or not, call 9, copy 5, indirect load 6, indirect store 6, add 5, compare 4, increment 5, return 8.
- R9: Secondary code 7 and primary opcodes 4 to 6 change no register, flag or memory word, and take 4 clocks.
- R10: `instrDone` is high for exactly the last clock of each instruction. `cycleCount` is 0 in the first clock after reset and increases by one each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 10 | Word address to memory |
| memRdata | input | 32 | Read word, valid one clock after the address |
| memWdata | output | 32 | Write word |
| memWe | output | 1 | Write strobe |
| instrDone | output | 1 | High in the last clock of an instruction |
| cycleCount | output | 32 | Clocks since reset |

## Verification
The bench steps a reference model through a program and checks every instruction. It compares the clock gap between completion pulses and the memory image against the model. This catches a missing or extra micro-step, which would shift every count after it. It also catches a push that writes before the stack pointer moves, which would overwrite the caller's frame, and a return that decrements first, which would jump to the wrong address. The bench runs all seven condition codes against equal, smaller, larger and negative operand pairs. It computes each expected branch outcome from signed comparison alone, so a condition that reads the wrong flag, or a flag updated by add or increment, leaves a wrong marker in memory. The reset flag state and the cleared registers are made visible by a branch and a store issued before any other instruction. Add overflow to zero and indirect accesses through a pointer register are checked by literal values.

// File: rtl/mc_cpu_pkg.sv
package mc_cpu_pkg;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_JUMP  = 3'd2;
  localparam logic [2:0] OP_CALL  = 3'd3;
  localparam logic [2:0] OP_EXT   = 3'd7;

  localparam logic [2:0] XOP_MOV = 3'd0;
  localparam logic [2:0] XOP_LDI = 3'd1;
  localparam logic [2:0] XOP_STI = 3'd2;
  localparam logic [2:0] XOP_ADD = 3'd3;
  localparam logic [2:0] XOP_CMP = 3'd4;
  localparam logic [2:0] XOP_INC = 3'd5;
  localparam logic [2:0] XOP_RET = 3'd6;

  typedef enum logic [1:0] {MAR_PC, MAR_ADS, MAR_REG} marSrc_e;
  typedef enum logic [1:0] {MDR_MEM, MDR_REG, MDR_PC} mdrSrc_e;
  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_INC, ALU_DEC} alu_e;
  typedef enum logic [1:0] {SEL_R, SEL_R1, SEL_R2, SEL_SP} regSel_e;

  typedef struct packed {
    logic    marLd;
    marSrc_e marSrc;
    logic    mdrLd;
    mdrSrc_e mdrSrc;
    logic    irLd;
    logic    pcInc;
    logic    pcLdAds;
    logic    pcLdCond;
    logic    pcLdMdr;
    logic    tLd;
    alu_e    aluOp;
    logic    regWr;
    logic    regFromMdr;
    regSel_e srcSel;
    regSel_e dstSel;
    logic    ccLd;
    logic    takeLd;
    logic    memWe;
  } ctl_t;

endpackage

// File: rtl/mc_cpu_ctrl.sv
module mc_cpu_ctrl
  import mc_cpu_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] op,
  input  logic [2:0] xop,
  output ctl_t       ctl,
  output logic       instrDone
);

  typedef enum logic [1:0] {ST_F0, ST_F1, ST_F2, ST_EX} state_e;
  typedef enum logic [3:0] {
    C_LOAD, C_STORE, C_JUMP, C_CALL, C_MOV, C_LDI, C_STI,
    C_ADD, C_CMP, C_INC, C_RET, C_NOP
  } cls_e;

  state_e            state;
  logic [STEP_W-1:0] step;
  cls_e              cls;
  logic              lastStep;

  always_comb begin
    cls = C_NOP;
    case (op)
      OP_LOAD:  cls = C_LOAD;
      OP_STORE: cls = C_STORE;
      OP_JUMP:  cls = C_JUMP;
      OP_CALL:  cls = C_CALL;
      OP_EXT: begin
        case (xop)
          XOP_MOV: cls = C_MOV;
          XOP_LDI: cls = C_LDI;
          XOP_STI: cls = C_STI;
          XOP_ADD: cls = C_ADD;
          XOP_CMP: cls = C_CMP;
          XOP_INC: cls = C_INC;
          XOP_RET: cls = C_RET;
          default: cls = C_NOP;
        endcase
      end
      default: cls = C_NOP;
    endcase
  end

  // micro-step table: one strobe set per clock
  always_comb begin
    ctl      = '0;
    lastStep = 1'b0;
    case (state)
      ST_F0: begin ctl.marLd = 1'b1; ctl.marSrc = MAR_PC; end
      ST_F1: begin ctl.mdrLd = 1'b1; ctl.mdrSrc = MDR_MEM; end
      ST_F2: begin ctl.irLd = 1'b1; ctl.pcInc = 1'b1; end
      default: begin
        case (cls)
          C_LOAD, C_LDI: begin
            case (step)
              0: begin
                ctl.marLd  = 1'b1;
                ctl.marSrc = (cls == C_LOAD) ? MAR_ADS : MAR_REG;
                ctl.srcSel = SEL_R1;
              end
              1: begin ctl.mdrLd = 1'b1; ctl.mdrSrc = MDR_MEM; end
              default: begin
                ctl.regWr = 1'b1; ctl.regFromMdr = 1'b1;
                ctl.dstSel = (cls == C_LOAD) ? SEL_R : SEL_R2;
                lastStep = 1'b1;
              end
            endcase
          end
          C_STORE: begin
            case (step)
              0: begin ctl.marLd = 1'b1; ctl.marSrc = MAR_ADS; end
              1: begin ctl.mdrLd = 1'b1; ctl.mdrSrc = MDR_REG; ctl.srcSel = SEL_R; end
              default: begin ctl.memWe = 1'b1; lastStep = 1'b1; end
            endcase
          end
          C_STI: begin
            case (step)
              0: begin ctl.mdrLd = 1'b1; ctl.mdrSrc = MDR_REG; ctl.srcSel = SEL_R1; end
              1: begin ctl.marLd = 1'b1; ctl.marSrc = MAR_REG; ctl.srcSel = SEL_R2; end
              default: begin ctl.memWe = 1'b1; lastStep = 1'b1; end
            endcase
          end
          C_JUMP: begin
            if (step == 0) ctl.takeLd = 1'b1;
            else begin ctl.pcLdCond = 1'b1; lastStep = 1'b1; end
          end
          C_CALL: begin
            case (step)
              0: begin ctl.tLd = 1'b1; ctl.aluOp = ALU_INC; ctl.srcSel = SEL_SP; end
              1: begin ctl.regWr = 1'b1; ctl.dstSel = SEL_SP; end
              2: begin ctl.marLd = 1'b1; ctl.marSrc = MAR_REG; ctl.srcSel = SEL_SP; end
              3: begin ctl.mdrLd = 1'b1; ctl.mdrSrc = MDR_PC; end
              4: ctl.memWe = 1'b1;
              default: begin ctl.pcLdAds = 1'b1; lastStep = 1'b1; end
            endcase
          end
          C_RET: begin
            case (step)
              0: begin ctl.marLd = 1'b1; ctl.marSrc = MAR_REG; ctl.srcSel = SEL_SP; end
              1: begin ctl.mdrLd = 1'b1; ctl.mdrSrc = MDR_MEM; end
              2: ctl.pcLdMdr = 1'b1;
              3: begin ctl.tLd = 1'b1; ctl.aluOp = ALU_DEC; ctl.srcSel = SEL_SP; end
              default: begin ctl.regWr = 1'b1; ctl.dstSel = SEL_SP; lastStep = 1'b1; end
            endcase
          end
          C_MOV, C_ADD, C_INC: begin
            if (step == 0) begin
              ctl.tLd    = 1'b1;
              ctl.srcSel = SEL_R1;
              ctl.aluOp  = (cls == C_MOV) ? ALU_PASS : (cls == C_ADD) ? ALU_ADD : ALU_INC;
            end else begin
              ctl.regWr  = 1'b1;
              ctl.dstSel = (cls == C_MOV) ? SEL_R2 : SEL_R1;
              lastStep   = 1'b1;
            end
          end
          C_CMP: begin ctl.ccLd = 1'b1; ctl.srcSel = SEL_R1; lastStep = 1'b1; end
          default: lastStep = 1'b1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_F0;
      step  <= '0;
    end else begin
      case (state)
        ST_F0: state <= ST_F1;
        ST_F1: state <= ST_F2;
        ST_F2: begin state <= ST_EX; step <= '0; end
        default: begin
          if (lastStep) state <= ST_F0;
          else          step  <= step + STEP_W'(1);
        end
      endcase
    end
  end

  assign instrDone = (state == ST_EX) && lastStep;

  AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (rst)
    state == ST_F0 |=> state == ST_F1); // R8
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    state == ST_EX |-> step <= STEP_W'(5)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    instrDone |=> !instrDone); // R10

endmodule

// File: rtl/mc_cpu_datapath.sv
module mc_cpu_datapath
  import mc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [2:0]        op,
  output logic [2:0]        xop
);

  localparam int RIDX_W = $clog2(NREG);
  localparam int OP_LSB = DATA_W - 3;
  localparam int R_LSB  = OP_LSB - RIDX_W;
  localparam int X_LSB  = R_LSB - 3;
  localparam int R1_LSB = X_LSB - RIDX_W;
  localparam int R2_LSB = R1_LSB - RIDX_W;
  localparam logic [RIDX_W-1:0] SP_IDX = RIDX_W'(NREG - 1);

  logic [DATA_W-1:0] rf [NREG];
  logic [DATA_W-1:0] ir, mdr, t;
  logic [ADDR_W-1:0] pc, mar;
  logic              zFlag, sFlag, taken;

  logic [RIDX_W-1:0] rF, r1F, r2F, srcIdx, dstIdx;
  logic [ADDR_W-1:0] ads, marNext;
  logic [DATA_W-1:0] regA, regB, aluOut, mdrNext, diff;
  logic              condOk;
  logic [R2_LSB-ADDR_W-1:0] unusedIrBits;

  assign op  = ir[OP_LSB +: 3];
  assign xop = ir[X_LSB +: 3];
  assign rF  = ir[R_LSB +: RIDX_W];
  assign r1F = ir[R1_LSB +: RIDX_W];
  assign r2F = ir[R2_LSB +: RIDX_W];
  assign ads = ir[ADDR_W-1:0];
  assign unusedIrBits = ir[R2_LSB-1:ADDR_W];

  always_comb begin
    case (ctl.srcSel)
      SEL_R:   srcIdx = rF;
      SEL_R1:  srcIdx = r1F;
      SEL_R2:  srcIdx = r2F;
      default: srcIdx = SP_IDX;
    endcase
    case (ctl.dstSel)
      SEL_R:   dstIdx = rF;
      SEL_R1:  dstIdx = r1F;
      SEL_R2:  dstIdx = r2F;
      default: dstIdx = SP_IDX;
    endcase
  end

  assign regA = rf[srcIdx];
  assign regB = rf[r2F];
  assign diff = regA - regB;

  always_comb begin
    case (ctl.aluOp)
      ALU_ADD: aluOut = regA + regB;
      ALU_INC: aluOut = regA + DATA_W'(1);
      ALU_DEC: aluOut = regA - DATA_W'(1);
      default: aluOut = regA;
    endcase
    case (ctl.marSrc)
      MAR_PC:  marNext = pc;
      MAR_ADS: marNext = ads;
      default: marNext = regA[ADDR_W-1:0];
    endcase
    case (ctl.mdrSrc)
      MDR_REG: mdrNext = regA;
      MDR_PC:  mdrNext = DATA_W'(pc);
      default: mdrNext = memRdata;
    endcase
    case (rF)
      3'd0:    condOk = 1'b1;
      3'd1:    condOk = zFlag;
      3'd2:    condOk = !zFlag;
      3'd3:    condOk = sFlag;
      3'd4:    condOk = sFlag || zFlag;
      3'd5:    condOk = !sFlag;
      3'd6:    condOk = !sFlag && !zFlag;
      default: condOk = 1'b0;
    endcase
  end

  // address goes out on the edge that loads MAR, so read data lands next clock
  assign memAddr  = ctl.marLd ? marNext : mar;
  assign memWdata = mdr;
  assign memWe    = ctl.memWe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; mar <= '0; ir <= '0; mdr <= '0; t <= '0;
      zFlag <= 1'b0; sFlag <= 1'b0; taken <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (ctl.marLd)  mar <= marNext;
      if (ctl.mdrLd)  mdr <= mdrNext;
      if (ctl.irLd)   ir  <= mdr;
      if (ctl.tLd)    t   <= aluOut;
      if (ctl.takeLd) taken <= condOk;
      if (ctl.ccLd) begin
        zFlag <= (regA == regB);
        sFlag <= diff[DATA_W-1];
      end
      if (ctl.pcInc)                     pc <= pc + ADDR_W'(1);
      else if (ctl.pcLdAds)              pc <= ads;
      else if (ctl.pcLdCond && taken)    pc <= ads;
      else if (ctl.pcLdMdr)              pc <= mdr[ADDR_W-1:0];
      if (ctl.regWr) rf[dstIdx] <= ctl.regFromMdr ? mdr : t;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    ctl.pcInc |=> pc == $past(pc) + ADDR_W'(1)); // R2
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.ccLd |=> $stable({zFlag, sFlag})); // R4
  AST_MDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.mdrLd |=> $stable(mdr)); // R3

endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
  import mc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int NREG   = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              instrDone,
  output logic [CNT_W-1:0]  cycleCount
);

  ctl_t       ctl;
  logic [2:0] op, xop;

  mc_cpu_ctrl #(.STEP_W(3)) u_ctrl (
    .clk(clk), .rst(rst), .op(op), .xop(xop), .ctl(ctl), .instrDone(instrDone)
  );

  mc_cpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .op(op), .xop(xop)
  );

  always_ff @(posedge clk) begin
    if (rst) cycleCount <= '0;
    else     cycleCount <= cycleCount + CNT_W'(1);
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cycleCount == $past(cycleCount) + CNT_W'(1)); // R10

endmodule

// File: tb/mc_cpu_tb.sv
module mc_cpu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  memAddr;
  logic [31:0] memRdata;
  logic [31:0] memWdata;
  logic        memWe;
  logic        instrDone;
  logic [31:0] cycleCount;

  logic [31:0] mem     [1024];
  logic [31:0] image   [1024];
  logic [31:0] issMem  [1024];
  logic [31:0] issR    [8];
  logic        issZ, issS;
  logic [9:0]  issPc;
  logic        loadEn = 1'b0;
  logic [9:0]  loadAddr = '0;
  logic [31:0] loadData = '0;

  int checks = 0;
  int fails  = 0;
  int p      = 0;
  int haltAddr;

  always #2.5 clk = ~clk;

  mc_cpu u_dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRdata(memRdata),
    .memWdata(memWdata), .memWe(memWe), .instrDone(instrDone), .cycleCount(cycleCount)
  );

  always @(posedge clk) begin
    if (loadEn)     mem[loadAddr] <= loadData;
    else if (memWe) mem[memAddr]  <= memWdata;
    memRdata <= mem[memAddr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R2 encodings
  function automatic logic [31:0] encP(input int op, input int r, input int ads);
    return {op[2:0], r[2:0], 16'd0, ads[9:0]};
  endfunction
  function automatic logic [31:0] encX(input int xo, input int r1, input int r2);
    return {3'd7, 3'd0, xo[2:0], r1[2:0], r2[2:0], 17'd0};
  endfunction

  task automatic emit(input logic [31:0] w);
    image[p] = w;
    p++;
  endtask

  function automatic bit condTrue(input int c, input logic z, input logic s);
    case (c)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return s;
      4: return s || z;
      5: return !s;
      6: return !s && !z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit signedTaken(input int c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      0: return 1'b1;
      1: return a == b;
      2: return a != b;
      3: return $signed(a) <  $signed(b);
      4: return $signed(a) <= $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return $signed(a) >  $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  task automatic issStep(output int clocks, output bit isNop, output bit isHalt);
    logic [31:0] w;
    int op, r, ads, xo, r1, r2;
    logic [31:0] d;
    w = issMem[issPc];
    op = int'(w[31:29]); r = int'(w[28:26]); ads = int'(w[9:0]);
    xo = int'(w[25:23]); r1 = int'(w[22:20]); r2 = int'(w[19:17]);
    isHalt = (int'(issPc) == haltAddr);
    isNop = 1'b0;
    issPc = issPc + 10'd1;
    case (op)
      0: begin issR[r] = issMem[ads]; clocks = 6; end
      1: begin issMem[ads] = issR[r]; clocks = 6; end
      2: begin if (condTrue(r, issZ, issS)) issPc = ads[9:0]; clocks = 5; end
      3: begin
        issR[7] = issR[7] + 32'd1;
        issMem[issR[7][9:0]] = {22'd0, issPc};
        issPc = ads[9:0];
        clocks = 9;
      end
      7: begin
        case (xo)
          0: begin issR[r2] = issR[r1]; clocks = 5; end
          1: begin issR[r2] = issMem[issR[r1][9:0]]; clocks = 6; end
          2: begin issMem[issR[r2][9:0]] = issR[r1]; clocks = 6; end
          3: begin issR[r1] = issR[r1] + issR[r2]; clocks = 5; end
          4: begin
            d = issR[r1] - issR[r2];
            issZ = (issR[r1] == issR[r2]);
            issS = d[31];
            clocks = 4;
          end
          5: begin issR[r1] = issR[r1] + 32'd1; clocks = 5; end
          6: begin
            issPc = issMem[issR[7][9:0]][9:0];
            issR[7] = issR[7] - 32'd1;
            clocks = 8;
          end
          default: begin isNop = 1'b1; clocks = 4; end
        endcase
      end
      default: begin isNop = 1'b1; clocks = 4; end
    endcase
  endtask

  int pa [5] = '{1, 1, 2, 3, 1};
  int pb [5] = '{1, 2, 1, 1, 3};
  logic [31:0] rv [4] = '{32'd0, 32'd5, 32'd9, 32'hFFFFFFFE};

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lastDone, cyc, clocks;
    bit isNop, isHalt, stop, same;
    logic [31:0] expR [8];

    for (int a = 0; a < 1024; a++) image[a] = 32'd0;
    image[250] = 32'd5;  image[251] = 32'd9;  image[252] = 32'hFFFFFFFE;
    image[253] = 32'd300; image[254] = 32'h7FFFFFFF; image[255] = 32'hA5;
    image[256] = 32'd350;
    image[397] = 32'h1234; image[398] = 32'hBEEF; image[399] = 32'hDEAD;

    p = 0;
    emit(encP(2, 1, 2));           // jump on zero: flags cleared, falls through
    emit(encP(1, 6, 399));         // cleared r6 stored
    emit(encP(1, 5, 398));         // cleared r5 stored
    emit(encP(0, 1, 250)); emit(encP(0, 2, 251)); emit(encP(0, 3, 252));
    emit(encP(0, 7, 253)); emit(encP(0, 6, 255));
    for (int i = 0; i < 5; i++) begin
      for (int c = 0; c < 7; c++) begin
        emit(encX(4, pa[i], pb[i]));
        emit(encP(2, c, p + 2));
        emit(encP(1, 6, 400 + i * 7 + c));
      end
    end
    emit(encX(4, 1, 2));           // 5 vs 9: Z=0 S=1
    emit(encX(0, 1, 4));
    emit(encX(3, 4, 2));
    emit(encP(0, 5, 254));
    emit(encX(5, 5, 0));
    emit(encX(3, 5, 5));           // wraps to zero, flags untouched
    emit(encP(0, 0, 256));
    emit(encX(2, 4, 0));
    emit(encX(1, 0, 3));
    emit(encP(2, 2, p + 2));       // not-zero must still be taken
    emit(encP(1, 6, 397));
    emit(encX(7, 0, 0));
    emit(encP(5, 0, 0));
    emit(encP(3, 0, 200));
    for (int i = 0; i < 8; i++) emit(encP(1, i, 500 + i));
    haltAddr = p;
    emit(encP(2, 0, p));
    image[200] = encX(5, 6, 0);
    image[201] = encP(3, 0, 205);
    image[202] = encX(6, 0, 0);
    image[205] = encX(3, 6, 1);
    image[206] = encX(6, 0, 0);

    for (int a = 0; a < 1024; a++) issMem[a] = image[a];
    for (int i = 0; i < 8; i++) issR[i] = 32'd0;
    issZ = 1'b0; issS = 1'b0; issPc = 10'd0;

    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = a[9:0]; loadData = image[a];
    end
    @(negedge clk);
    loadEn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check(memAddr == 10'd0, "R1", "first fetch address", memAddr, 0);
    check(instrDone == 1'b0, "R10", "done after reset", instrDone, 0);
    check(cycleCount == 32'd0, "R10", "count after reset", cycleCount, 0);
    check(memWe == 1'b0, "R1", "write after reset", memWe, 0);

    lastDone = -1;
    stop = 1'b0;
    while (!stop) begin
      @(negedge clk);
      if (instrDone) begin
        cyc = int'(cycleCount);
        issStep(clocks, isNop, isHalt);
        if (isNop) check(cyc - lastDone == clocks, "R9 R10", "no-op clocks", cyc - lastDone, clocks);
        else       check(cyc - lastDone == clocks, "R8 R10", "instruction clocks", cyc - lastDone, clocks);
        lastDone = cyc;
        @(negedge clk);
        same = 1'b1;
        for (int a = 0; a < 512; a++) if (mem[a] !== issMem[a]) same = 1'b0;
        check(same, "R2 R3 R5 R6 R7", "memory image vs model", 0, 0);
        if (isHalt) stop = 1'b1;
      end
    end

    check(mem[399] == 32'd0, "R1", "cleared reg after zero-flag branch", mem[399], 0);
    check(mem[398] == 32'd0, "R1", "cleared register", mem[398], 0);
    for (int i = 0; i < 5; i++) begin
      for (int c = 0; c < 7; c++) begin
        logic [31:0] e;
        e = signedTaken(c, rv[pa[i]], rv[pb[i]]) ? 32'd0 : 32'hA5;
        check(mem[400 + i * 7 + c] == e, "R4", "branch marker", mem[400 + i * 7 + c], e);
      end
    end
    check(mem[397] == 32'h1234, "R4", "flags kept across add", mem[397], 32'h1234);
    expR = '{32'd350, 32'd5, 32'd9, 32'd14, 32'd14, 32'd0, 32'hAB, 32'd300};
    check(mem[500] == expR[0], "R6", "pointer register", mem[500], expR[0]);
    check(mem[501] == expR[1], "R3", "loaded register", mem[501], expR[1]);
    check(mem[502] == expR[2], "R3", "loaded register", mem[502], expR[2]);
    check(mem[503] == expR[3], "R6", "indirect load result", mem[503], expR[3]);
    check(mem[504] == expR[4], "R5", "move then add", mem[504], expR[4]);
    check(mem[505] == expR[5], "R5", "add wraps to zero", mem[505], expR[5]);
    check(mem[506] == expR[6], "R7", "nested call body", mem[506], expR[6]);
    check(mem[507] == expR[7], "R7", "stack pointer restored", mem[507], expR[7]);
    check(mem[350] == 32'd14, "R6", "indirect store", mem[350], 14);
    check(mem[302] == 32'd202, "R7", "inner return address", mem[302], 202);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule